// File: doc/BRIEF.md
# Job Ring Occupancy and Interrupt Controller

This block keeps the books for a pair of descriptor rings that sit between software and a processing engine. Jobs go into an input ring and completed-job entries come back on an output ring. Software sets the size of each ring and then, through a small register port, tells the block how many jobs it has placed in the input ring and how many results it has taken off the output ring. The engine side raises one-cycle pulses: a consume pulse when it wants the next job and a complete pulse when it wants to post a result. The block grants or refuses each pulse, hands out the slot index to use, and wraps the indices at the programmed ring size.

Completions set an interrupt flag. The flag can be set on every completion, or coalesced so that it is set only after a programmed number of unsignalled completions, or after a programmed number of clock ticks since the first of them, whichever comes first. Software misuse (adding more jobs than there are free slots, or removing more results than are present) is refused and reported as a coded error that carries the ring index. The error can optionally freeze the engine side. A ring-reset command empties both rings and reports a two-step halt status. Descriptor fetch, memory traffic and ring contents are handled elsewhere.

Top module: `jobring_occ_irq`

## Requirements
- R1: Register word addresses on `reg_addr` are: 0 config, 1 interrupt status, 2 command, 4 input size, 5 input free slots, 6 input jobs-added (write only, reads 0), 7 input read index, 8 output size, 9 output full slots, 10 output jobs-removed (write only, reads 0), 11 output write index. After reset every readable register returns 0 and `irq` is 0.
- R2: Writing the input size (bits 9:0) sets the free-slot count to that size and the read index to 0. Writing the output size sets the full-slot count and the write index to 0.
- R3: Writing N (bits 9:0) to jobs-added lowers the free-slot count by N when N is not above it. Otherwise the count is unchanged and the status gets bit 1 (error) set, bits 11:8 set to 9, and bits 29:16 set to the input read index.
- R4: Writing N to jobs-removed lowers the full-slot count by N when N is not above it. Otherwise the count is unchanged and the status gets bit 1 set, bits 11:8 set to 8, and bits 29:16 set to the output write index.
- R5: A consume pulse is granted (`eng_take`=1, `take_slot` = read index) only while the free count is below the input size. A grant raises the free count by one and moves the read index on, wrapping to 0 after size-1. With the free count equal to the size, the pulse is ignored.
- R6: `cmp_ready` is 1 only while the full count is below the output size. A complete pulse with `cmp_ready`=1 posts at `cmp_slot` = write index, raises the full count and moves the write index on with wrap. With the ring full the pulse stalls and nothing changes.
- R7: With coalescing off (config bit 1 = 0), each accepted completion sets status bit 0 at the same clock edge. `irq` is 1 when config bit 0 is 0 and status bit 0 or bit 1 is set.
- R8: With coalescing on, status bit 0 is set at the edge of the accepted completion that brings the unsignalled count to the threshold in config bits 15:8 (0 counts as 1).
- R9: With coalescing on, status bit 0 is also set T edges after the first unsignalled completion, where T is config bits 31:16 (0 counts as 1), if the count threshold has not been met first.
- R10: Writing the status register with bit 0 or bit 1 set clears that flag. Writing it with a bit at 0 leaves that flag as it is.
- R11: With config bit 2 set and the error flag set, no consume is granted and `cmp_ready` is 0. Clearing the flag releases both sides.
- R12: Writing command bit 0 empties both rings (free count back to the input size, full count 0, both indices 0) and clears status bits 0 and 1. It records type 7 in bits 11:8 and sets the halt field (bits 3:2) to 1 for one cycle and then to 2. While the halt field is 1, the engine side is held off. The command register always reads 0. A status write with bit 3 set returns halt 2 to 0.
- R13: While config bit 0 (mask) is set, `irq` is 0 even when status flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address, also selects read data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_consume | input | 1 | Engine asks for the next input job |
| eng_take | output | 1 | Consume granted this cycle |
| take_slot | output | IDX_W | Input slot handed to the engine |
| eng_complete | input | 1 | Engine wants to post a result |
| cmp_ready | output | 1 | Output ring can accept a result |
| cmp_slot | output | IDX_W | Output slot the next result goes to |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the exact refusal thresholds. Adding one job more than the free count must leave the count untouched and report type 9 with the read index, and a design that compared with greater-or-equal, or that subtracted anyway, would show a wrong count or a missing error. It drives consumes past an empty input ring and completions into a full output ring, where an off-by-one in the bound would hand out a spare slot. It also runs indices across the wrap point, where a bad wrap would give slot 4 on a ring of 4. For coalescing it samples the flag one edge before and exactly at the count and timer limits, so a timer that starts a cycle late or fires a cycle early is exposed. The reset command is checked for the one-cycle halt-in-progress step, the hold-off of the engine side and the restored free count.

// File: rtl/jobring_pkg.sv
// Package: shared register addresses, field widths and status codes
// for the job ring occupancy and interrupt controller.
package jobring_pkg;

    // Register word addresses
    localparam logic [3:0] A_CFG     = 4'd0;
    localparam logic [3:0] A_STATUS  = 4'd1;
    localparam logic [3:0] A_CMD     = 4'd2;
    localparam logic [3:0] A_IN_SIZE = 4'd4;
    localparam logic [3:0] A_IN_FREE = 4'd5;
    localparam logic [3:0] A_IN_ADD  = 4'd6;
    localparam logic [3:0] A_IN_RIDX = 4'd7;
    localparam logic [3:0] A_OUT_SIZE = 4'd8;
    localparam logic [3:0] A_OUT_FULL = 4'd9;
    localparam logic [3:0] A_OUT_REM  = 4'd10;
    localparam logic [3:0] A_OUT_WIDX = 4'd11;

    // Fixed field widths of the config and status words
    localparam int unsigned CNT_THR_W = 8;
    localparam int unsigned TMR_THR_W = 16;
    localparam int unsigned ERR_IDX_W = 14;

    typedef enum logic [3:0] {
        ERR_NONE    = 4'd0,
        ERR_RESET   = 4'd7,
        ERR_REM_OVF = 4'd8,
        ERR_ADD_OVF = 4'd9
    } jr_err_e;

    typedef enum logic [1:0] {
        HALT_IDLE = 2'd0,
        HALT_BUSY = 2'd1,
        HALT_DONE = 2'd2
    } jr_halt_e;

endpackage

// File: rtl/jobring_track.sv
// Module: one ring's occupancy counter and wrapping slot index.
// The level counts free slots (input ring, START_FULL=1) or full slots
// (output ring, START_FULL=0). Engine events raise the level by one while
// level < size; software lowers it by N unless N exceeds the level.
// Assumes: size write and flush never coincide with each other.
module jobring_track #(
    parameter int unsigned IDX_W      = 10,
    parameter bit          START_FULL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             size_we,
    input  logic [IDX_W-1:0] size_wd,
    input  logic             flush,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_n,
    input  logic             eng_evt,
    input  logic             hold,
    output logic [IDX_W-1:0] size_q,
    output logic [IDX_W-1:0] level_q,
    output logic [IDX_W-1:0] idx_q,
    output logic             room,
    output logic             eng_ok,
    output logic             sw_ovf
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    logic [IDX_W-1:0] fresh_level;
    logic [IDX_W-1:0] dec_n;
    logic [IDX_W:0]   level_sum;
    logic             idx_last;

    // Level a ring starts from after a size write or flush
    generate
        if (START_FULL) begin : g_free
            assign fresh_level = size_we ? size_wd : size_q;
        end else begin : g_full
            assign fresh_level = '0;
        end
    endgenerate

    // Event qualification and next-level arithmetic
    always_comb begin
        room      = ~hold & (level_q < size_q);
        eng_ok    = eng_evt & room;
        sw_ovf    = sw_we & (sw_n > level_q);
        dec_n     = (sw_we & ~sw_ovf) ? sw_n : '0;
        level_sum = {1'b0, level_q} + (IDX_W+1)'(eng_ok) - {1'b0, dec_n};
        idx_last  = (idx_q == size_q - ONE);
    end

    // Ring size register
    always_ff @(posedge clk) begin
        if (!rst_n)       size_q <= '0;
        else if (size_we) size_q <= size_wd;
    end

    // Occupancy level and slot index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            idx_q   <= '0;
        end else if (size_we || flush) begin
            level_q <= fresh_level;
            idx_q   <= '0;
        end else begin
            level_q <= level_sum[IDX_W-1:0];
            if (eng_ok) idx_q <= idx_last ? '0 : idx_q + ONE;
        end
    end

endmodule

// File: rtl/jobring_coalesce.sv
// Module: completion interrupt coalescing. Emits a one-cycle fire when an
// accepted completion brings the unsignalled count to the count threshold,
// or when the tick count since the first unsignalled completion reaches the
// timer threshold. A threshold of 0 acts as 1. Disabled: fires per completion.
module jobring_coalesce
    import jobring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 enable,
    input  logic [CNT_THR_W-1:0] cnt_thr,
    input  logic [TMR_THR_W-1:0] tmr_thr,
    input  logic                 post,
    output logic                 fire
);
    logic [CNT_THR_W:0]   cnt_q;
    logic [CNT_THR_W:0]   cnt_n;
    logic [CNT_THR_W:0]   eff_cnt;
    logic [TMR_THR_W:0]   eff_tmr;
    logic [TMR_THR_W-1:0] tmr_q;
    logic                 hit_cnt;
    logic                 hit_tmr;

    // Threshold decode and fire condition
    always_comb begin
        eff_cnt = (cnt_thr == '0) ? (CNT_THR_W+1)'(1) : {1'b0, cnt_thr};
        eff_tmr = (tmr_thr == '0) ? (TMR_THR_W+1)'(1) : {1'b0, tmr_thr};
        cnt_n   = cnt_q + (CNT_THR_W+1)'(post);
        hit_cnt = post & (cnt_n >= eff_cnt);
        hit_tmr = (cnt_q != '0) & (({1'b0, tmr_q} + (TMR_THR_W+1)'(1)) >= eff_tmr);
        fire    = enable ? (hit_cnt | hit_tmr) : post;
    end

    // Unsignalled completion count and age timer
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q <= '0;
            tmr_q <= '0;
        end else if (!enable || fire) begin
            cnt_q <= '0;
            tmr_q <= '0;
        end else if (cnt_n != '0) begin
            cnt_q <= cnt_n;
            tmr_q <= (cnt_q == '0) ? '0 : tmr_q + TMR_THR_W'(1);
        end
    end

endmodule

// File: rtl/jobring_occ_irq.sv
// Module: top of the job ring occupancy and interrupt controller.
// Decodes the register port, holds config and status, and joins two ring
// trackers with the coalescing unit. Assumes IDX_W <= 14 and one register
// access per cycle; reads are combinational on reg_addr.
module jobring_occ_irq
    import jobring_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             eng_consume,
    output logic             eng_take,
    output logic [IDX_W-1:0] take_slot,
    input  logic             eng_complete,
    output logic             cmp_ready,
    output logic [IDX_W-1:0] cmp_slot,
    output logic             irq
);
    // Write decode
    logic we_cfg, we_stat, we_cmd, we_insz, we_add, we_outsz, we_rem, flush;
    // Config fields
    logic                 cfg_mask_q, cfg_coal_q, cfg_soe_q;
    logic [CNT_THR_W-1:0] cfg_cthr_q;
    logic [TMR_THR_W-1:0] cfg_tthr_q;
    // Status fields
    logic                 int_flag_q, err_flag_q;
    jr_err_e              err_type_q;
    logic [ERR_IDX_W-1:0] err_idx_q;
    jr_halt_e             halt_q;
    // Ring tracker views
    logic [IDX_W-1:0] in_size, in_free, in_ridx;
    logic [IDX_W-1:0] out_size, out_full, out_widx;
    logic             in_room, in_ovf, out_room, out_ok, out_ovf;
    logic             hold, fire;
    logic [31:0]      status_word, cfg_word;

    // Register write strobes
    always_comb begin
        we_cfg   = reg_wr && reg_addr == A_CFG;
        we_stat  = reg_wr && reg_addr == A_STATUS;
        we_cmd   = reg_wr && reg_addr == A_CMD;
        we_insz  = reg_wr && reg_addr == A_IN_SIZE;
        we_add   = reg_wr && reg_addr == A_IN_ADD;
        we_outsz = reg_wr && reg_addr == A_OUT_SIZE;
        we_rem   = reg_wr && reg_addr == A_OUT_REM;
        flush    = we_cmd && reg_wdata[0];
        hold     = (halt_q == HALT_BUSY) || (err_flag_q && cfg_soe_q);
    end

    // Input ring: level counts free slots
    jobring_track #(.IDX_W(IDX_W), .START_FULL(1'b1)) u_in (
        .clk(clk), .rst_n(rst_n),
        .size_we(we_insz), .size_wd(reg_wdata[IDX_W-1:0]), .flush(flush),
        .sw_we(we_add), .sw_n(reg_wdata[IDX_W-1:0]),
        .eng_evt(eng_consume), .hold(hold),
        .size_q(in_size), .level_q(in_free), .idx_q(in_ridx),
        .room(in_room), .eng_ok(eng_take), .sw_ovf(in_ovf)
    );

    // Output ring: level counts full slots
    jobring_track #(.IDX_W(IDX_W), .START_FULL(1'b0)) u_out (
        .clk(clk), .rst_n(rst_n),
        .size_we(we_outsz), .size_wd(reg_wdata[IDX_W-1:0]), .flush(flush),
        .sw_we(we_rem), .sw_n(reg_wdata[IDX_W-1:0]),
        .eng_evt(eng_complete), .hold(hold),
        .size_q(out_size), .level_q(out_full), .idx_q(out_widx),
        .room(out_room), .eng_ok(out_ok), .sw_ovf(out_ovf)
    );

    // Completion interrupt coalescing
    jobring_coalesce u_coal (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enable(cfg_coal_q), .cnt_thr(cfg_cthr_q), .tmr_thr(cfg_tthr_q),
        .post(out_ok), .fire(fire)
    );

    // Engine-side outputs
    always_comb begin
        take_slot = in_ridx;
        cmp_ready = out_room;
        cmp_slot  = out_widx;
        irq       = ~cfg_mask_q & (int_flag_q | err_flag_q);
    end

    // Config register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mask_q <= 1'b0;
            cfg_coal_q <= 1'b0;
            cfg_soe_q  <= 1'b0;
            cfg_cthr_q <= '0;
            cfg_tthr_q <= '0;
        end else if (we_cfg) begin
            cfg_mask_q <= reg_wdata[0];
            cfg_coal_q <= reg_wdata[1];
            cfg_soe_q  <= reg_wdata[2];
            cfg_cthr_q <= reg_wdata[8 +: CNT_THR_W];
            cfg_tthr_q <= reg_wdata[16 +: TMR_THR_W];
        end
    end

    // Interrupt status, error record and halt sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_flag_q <= 1'b0;
            err_flag_q <= 1'b0;
            err_type_q <= ERR_NONE;
            err_idx_q  <= '0;
            halt_q     <= HALT_IDLE;
        end else if (flush) begin
            int_flag_q <= 1'b0;
            err_flag_q <= 1'b0;
            err_type_q <= ERR_RESET;
            err_idx_q  <= '0;
            halt_q     <= HALT_BUSY;
        end else begin
            int_flag_q <= fire | (int_flag_q & ~(we_stat & reg_wdata[0]));
            if (in_ovf) begin
                err_flag_q <= 1'b1;
                err_type_q <= ERR_ADD_OVF;
                err_idx_q  <= ERR_IDX_W'(in_ridx);
            end else if (out_ovf) begin
                err_flag_q <= 1'b1;
                err_type_q <= ERR_REM_OVF;
                err_idx_q  <= ERR_IDX_W'(out_widx);
            end else if (we_stat && reg_wdata[1]) begin
                err_flag_q <= 1'b0;
            end
            if (halt_q == HALT_BUSY)
                halt_q <= HALT_DONE;
            else if (halt_q == HALT_DONE && we_stat && reg_wdata[3])
                halt_q <= HALT_IDLE;
        end
    end

    // Read-back words and address mux
    always_comb begin
        status_word = {2'b00, err_idx_q, 4'b0000, err_type_q, 4'b0000,
                       halt_q, err_flag_q, int_flag_q};
        cfg_word    = {cfg_tthr_q, cfg_cthr_q, 5'b00000,
                       cfg_soe_q, cfg_coal_q, cfg_mask_q};
        case (reg_addr)
            A_CFG:      reg_rdata = cfg_word;
            A_STATUS:   reg_rdata = status_word;
            A_IN_SIZE:  reg_rdata = 32'(in_size);
            A_IN_FREE:  reg_rdata = 32'(in_free);
            A_IN_RIDX:  reg_rdata = 32'(in_ridx);
            A_OUT_SIZE: reg_rdata = 32'(out_size);
            A_OUT_FULL: reg_rdata = 32'(out_full);
            A_OUT_WIDX: reg_rdata = 32'(out_widx);
            default:    reg_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/jobring_occ_irq_chk.sv
// Checker: temporal properties of the job ring controller, bound to the top.
module jobring_occ_irq_chk
    import jobring_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             eng_consume,
    input logic             eng_take,
    input logic             cmp_ready,
    input logic             irq,
    input logic [IDX_W-1:0] in_size,
    input logic [IDX_W-1:0] in_free,
    input logic [IDX_W-1:0] out_size,
    input logic [IDX_W-1:0] out_full,
    input logic [1:0]       halt,
    input logic             err_flag,
    input logic [3:0]       err_type,
    input logic             cfg_mask,
    input logic             cfg_soe
);
    p_free_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_free <= in_size);

    p_full_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_full <= out_size);

    p_no_take_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_consume && in_free == in_size) |-> !eng_take);

    p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full == out_size) |-> !cmp_ready);

    p_add_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IN_ADD && reg_wdata[IDX_W-1:0] > in_free)
        |=> (err_flag && err_type == 4'd9));

    p_stop_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && cfg_soe) |-> (!eng_take && !cmp_ready));

    p_halt_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt == 2'd1 && !(reg_wr && reg_addr == A_CMD && reg_wdata[0]))
        |=> (halt == 2'd2));

    p_irq_mask_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mask |-> !irq);
endmodule

bind jobring_occ_irq jobring_occ_irq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_consume(eng_consume), .eng_take(eng_take),
    .cmp_ready(cmp_ready), .irq(irq), .in_size(in_size), .in_free(in_free),
    .out_size(out_size), .out_full(out_full), .halt(halt_q),
    .err_flag(err_flag_q), .err_type(err_type_q), .cfg_mask(cfg_mask_q),
    .cfg_soe(cfg_soe_q)
);

// File: tb/jobring_occ_irq_tb.sv
`timescale 1ns/10ps
// Bench: directed stimulus with a scoreboard on output slot assignment.
module jobring_occ_irq_tb;
    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [3:0]       reg_addr = 4'd0;
    logic [31:0]      reg_wdata = 32'd0;
    logic [31:0]      reg_rdata;
    logic             eng_consume = 1'b0;
    logic             eng_take;
    logic [IDX_W-1:0] take_slot;
    logic             eng_complete = 1'b0;
    logic             cmp_ready;
    logic [IDX_W-1:0] cmp_slot;
    logic             irq;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    int model_w = 0;
    int out_sz = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    jobring_occ_irq #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_consume(eng_consume), .eng_take(eng_take), .take_slot(take_slot),
        .eng_complete(eng_complete), .cmp_ready(cmp_ready), .cmp_slot(cmp_slot),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #0.5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // Driver: request one completion; push the expected slot when it should post
    task automatic do_complete(input bit accept, input string tag);
        if (accept) begin
            exp_q.push_back(model_w);
            model_w = (model_w + 1) % out_sz;
        end
        eng_complete = 1'b1;
        #0.1;
        chk(tag, {31'd0, cmp_ready}, {31'd0, accept});
        tick();
        eng_complete = 1'b0;
    endtask

    // Monitor: every accepted completion must match the next expected slot
    always @(negedge clk) begin
        if (rst_n && eng_complete && cmp_ready) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R6 unexpected post act=%0d exp=none", cmp_slot);
            end else begin
                chk("R6 posted slot", 32'(cmp_slot), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 status", 4'd1, 32'h0);
        rd_chk("R1 free", 4'd5, 32'h0);
        rd_chk("R1 full", 4'd9, 32'h0);
        rd_chk("R1 add reads 0", 4'd6, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2 sizes
        wr(4'd4, 32'd4);
        wr(4'd8, 32'd3); out_sz = 3;
        rd_chk("R2 free after size", 4'd5, 32'd4);
        rd_chk("R2 full after size", 4'd9, 32'd0);
        rd_chk("R2 ridx", 4'd7, 32'd0);

        // R3 add and add overflow
        wr(4'd6, 32'd3);
        rd_chk("R3 free after add", 4'd5, 32'd1);
        wr(4'd6, 32'd2);
        rd_chk("R3 free unchanged", 4'd5, 32'd1);
        rd_chk("R3 status add ovf", 4'd1, 32'h0000_0902);
        chk("R7 irq on error", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'd2);
        rd_chk("R10 error cleared", 4'd1, 32'h0000_0900);

        // R5 consume until empty, then wrap
        eng_consume = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #0.1;
            chk("R5 take", {31'd0, eng_take}, {31'd0, k < 3});
            if (k < 3) chk("R5 take slot", 32'(take_slot), k);
            tick();
        end
        eng_consume = 1'b0;
        rd_chk("R5 free back to size", 4'd5, 32'd4);
        rd_chk("R5 ridx", 4'd7, 32'd3);
        wr(4'd6, 32'd4);
        eng_consume = 1'b1;
        tick(); tick();
        eng_consume = 1'b0;
        rd_chk("R5 ridx wrapped", 4'd7, 32'd1);
        rd_chk("R5 free", 4'd5, 32'd2);

        // R6 and R7 completions without coalescing
        wr(4'd0, 32'd0);
        do_complete(1'b1, "R6 ready slot0");
        rd(4'd1, v);
        chk("R7 int flag", v & 32'h1, 32'h1);
        chk("R7 irq", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'd1);
        do_complete(1'b1, "R6 ready slot1");
        do_complete(1'b1, "R6 ready slot2");
        do_complete(1'b0, "R6 stall when full");
        rd_chk("R6 full", 4'd9, 32'd3);
        rd_chk("R6 widx wrapped", 4'd11, 32'd0);
        // R4 remove and remove overflow
        wr(4'd10, 32'd2);
        rd_chk("R4 full after remove", 4'd9, 32'd1);
        wr(4'd10, 32'd5);
        rd_chk("R4 full unchanged", 4'd9, 32'd1);
        rd(4'd1, v);
        chk("R4 type", (v >> 8) & 32'hf, 32'd8);
        chk("R4 index", (v >> 16) & 32'h3fff, 32'd0);
        chk("R4 error flag", (v >> 1) & 32'h1, 32'd1);
        wr(4'd1, 32'd3);
        do_complete(1'b1, "R6 ready after remove");

        // R13 mask
        wr(4'd0, 32'd1);
        do_complete(1'b1, "R6 ready masked");
        rd(4'd1, v);
        chk("R13 flag set", v & 32'h1, 32'h1);
        chk("R13 irq masked", {31'd0, irq}, 32'd0);
        wr(4'd0, 32'd0);
        chk("R13 irq unmasked", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'd1);
        wr(4'd10, 32'd3);

        // R8 count coalescing
        wr(4'd0, 32'd2 | (32'd3 << 8) | (32'd100 << 16));
        do_complete(1'b1, "R8 c1");
        do_complete(1'b1, "R8 c2");
        rd(4'd1, v);
        chk("R8 not yet", v & 32'h1, 32'h0);
        do_complete(1'b1, "R8 c3");
        rd(4'd1, v);
        chk("R8 fired at threshold", v & 32'h1, 32'h1);
        wr(4'd10, 32'd3);
        wr(4'd1, 32'd1);

        // R9 timer coalescing
        wr(4'd0, 32'd2 | (32'd8 << 8) | (32'd5 << 16));
        do_complete(1'b1, "R9 c1");
        for (int k = 0; k < 4; k++) tick();
        rd(4'd1, v);
        chk("R9 one edge early", v & 32'h1, 32'h0);
        tick();
        rd(4'd1, v);
        chk("R9 fired at timer", v & 32'h1, 32'h1);
        wr(4'd10, 32'd1);
        wr(4'd1, 32'd1);

        // R11 stop on error
        wr(4'd0, 32'd4);
        wr(4'd6, 32'd10);
        eng_consume = 1'b1;
        #0.1;
        chk("R11 no take", {31'd0, eng_take}, 32'd0);
        chk("R11 not ready", {31'd0, cmp_ready}, 32'd0);
        tick();
        eng_consume = 1'b0;
        rd_chk("R11 free unchanged", 4'd5, 32'd2);
        wr(4'd1, 32'd2);
        chk("R11 ready released", {31'd0, cmp_ready}, 32'd1);
        eng_consume = 1'b1;
        #0.1;
        chk("R11 take released", {31'd0, eng_take}, 32'd1);
        eng_consume = 1'b0;

        // R12 ring reset
        wr(4'd0, 32'd0);
        wr(4'd2, 32'd1);
        rd_chk("R12 halt busy", 4'd1, 32'h0000_0704);
        chk("R12 engine held", {31'd0, cmp_ready}, 32'd0);
        rd_chk("R12 free", 4'd5, 32'd4);
        rd_chk("R12 full", 4'd9, 32'd0);
        rd_chk("R12 ridx", 4'd7, 32'd0);
        rd_chk("R12 widx", 4'd11, 32'd0);
        rd_chk("R12 cmd reads done", 4'd2, 32'd0);
        tick();
        rd_chk("R12 halt done", 4'd1, 32'h0000_0708);
        wr(4'd1, 32'd8);
        rd_chk("R12 halt cleared", 4'd1, 32'h0000_0700);

        chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1;
        finish_run();
    end
endmodule